// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver with Hunt and Sync

This block sits behind a serial line receiver. On every clock where the bit-rate enable is high it samples one received bit. It then looks for bit-oriented frames of the kind used by the SDLC and HDLC link layers.

After reset the receiver is in hunt mode and ignores the data on the line. When it sees the flag pattern it moves to sync mode and reports the change once. In sync mode it works on the bits between flags:

- It deletes the zero that the transmitter inserts after five ones.
- It builds bytes from the remaining bits, least significant bit first.
- It hands every byte downstream as ordinary data, and this includes the two check bytes at the end of the frame.

While a frame is arriving, the receiver does not know which bytes are payload and which are check bytes. It learns where the frame ends only when the closing flag completes. At that same sample it hands over the final byte together with an end-of-frame mark and a CRC verdict.

A run of seven ones is an abort. It returns the receiver to hunt mode. A configuration input that marks the link as idling with flags silences the status-change event for such an abort.

A separate sync output pulses for one bit time each time the raw bit stream matches the flag. It works in both modes.

Top module: `sdlc_rx_hunt`

## Requirements
- R1: After reset `inSync`, `syncPulse`, `byteValid`, `frameEnd`, `crcErr`, `abortSeen` and `huntChange` are all 0 (hunt mode).
- R2: In hunt mode, the raw bit sequence 0,1,1,1,1,1,1,0 (the flag, 0x7E) sets `inSync` to 1 and gives one single-clock `huntChange` pulse.
- R3: `syncPulse` is high for exactly one bit time for each flag match in the raw stream. It rises at the bit-enable sample after the one that took the flag's last bit. This holds in both modes.
- R4: In sync mode a 0 that follows five consecutive 1s is deleted. The remaining bits are packed into bytes, with the first received bit as bit 0. Each byte is shown on `byteData` with a single-clock `byteValid` pulse.
- R5: Every byte between two flags is delivered as data, including both CRC bytes. The final byte is strobed in the same clock as the single-clock `frameEnd`, at the sample of the closing flag's last bit. Every earlier byte has `frameEnd` = 0.
- R6: The CRC is computed over all bits between the flags in arrival order. It uses polynomial x^16+x^12+x^5+1, is preset to 0xFFFF and shifts MSB out first. `crcErr` is loaded with `frameEnd`: 1 if the residue differs from 0x1D0F, else 0. It holds that value until the next `frameEnd`.
- R7: A frame with fewer than two whole bytes between flags produces no `byteValid` and no `frameEnd`.
- R8: Seven consecutive 1s in sync mode clear `inSync`, give one `abortSeen` pulse, give one `huntChange` pulse when `flagIdle` = 0, and produce no `frameEnd` for the partial frame.
- R9: With `flagIdle` = 1 an abort still clears `inSync` and pulses `abortSeen`, but no `huntChange` pulse occurs.
- R10: In hunt mode no `byteValid` or `frameEnd` is produced for any input other than the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Bit-rate sample enable, one clock per bit |
| rxBit | input | 1 | Received serial data |
| flagIdle | input | 1 | Line idles with flags: suppress abort status event |
| inSync | output | 1 | 1 in sync mode, 0 in hunt mode |
| syncPulse | output | 1 | One-bit-time pulse after each raw flag match |
| huntChange | output | 1 | Single-clock hunt/sync change event |
| byteValid | output | 1 | Single-clock strobe for `byteData` |
| byteData | output | 8 | Received byte, first bit in bit 0 |
| frameEnd | output | 1 | Single-clock end of frame, with the last byte |
| crcErr | output | 1 | CRC verdict of the last completed frame |
| abortSeen | output | 1 | Single-clock abort event |

## Verification
The bench sends payloads containing 0xFF and 0x7E, which force inserted zeros. A receiver that kept those zeros would shift every later byte and break the CRC.

The syncPulse timing is checked in the bit times around a flag. An off-by-one comparator would show the pulse one bit early or hold it for two bit times.

A one-byte frame catches a receiver that releases a lone byte or flags an end of frame without a CRC. A corrupted CRC followed by a clean frame catches a sticky or inverted `crcErr`.

Aborts are sent with `flagIdle` at both values. An abort in mid-frame has to drop the unfinished byte and end no frame, and the status event has to appear only when flag idling is off.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic frameRst;   // restart byte assembly and CRC
    logic loadByte;   // capture the assembled byte
  } rxCmd_t;

  // datapath -> control status, valid in the sample cycle
  typedef struct packed {
    logic flagHit;    // raw stream completes the flag this sample
    logic abortHit;   // this sample is the seventh consecutive one
    logic byteDone;   // a byte completes in the assembler this sample
    logic lenOk;      // at least one byte completed earlier in this frame
    logic crcOk;      // residue after this bit equals the good value
  } rxStat_t;

endpackage

// File: rtl/sdlc_rx_dp.sv
module sdlc_rx_dp
  import sdlc_rx_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter logic [CW-1:0] INIT = 16'hFFFF,
  parameter logic [CW-1:0] GOOD = 16'h1D0F,
  parameter int unsigned STUFF = 5,
  parameter int unsigned ABORT = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitEn,
  input  logic         rxBit,
  input  rxCmd_t       cmd,
  output rxStat_t      stat,
  output logic         flagNowReg,
  output logic [W-1:0] byteData
);

  localparam logic [W-1:0] FLAG = {1'b0, {(W-2){1'b1}}, 1'b0};
  localparam int unsigned OCW = $clog2(ABORT + 1);
  localparam int unsigned BCW = $clog2(W);
  localparam int unsigned FCW = $clog2(W + 1);

  logic [W-1:0]   rawSh, rawNext;
  logic [W-1:0]   dly, asmReg, asmNext;
  logic [OCW-1:0] ones;
  logic [BCW-1:0] bitCnt;
  logic [FCW-1:0] fill;
  logic [1:0]     byteCnt;
  logic [CW-1:0]  crc, crcNext;
  logic           dropZero, keep, outBit, primed, useBit;

  assign rawNext  = {rxBit, rawSh[W-1:1]};
  assign dropZero = !rxBit && (ones == OCW'(STUFF));
  assign keep     = bitEn && !dropZero;
  assign outBit   = dly[0];
  assign primed   = (fill == FCW'(W));
  assign useBit   = keep && primed;
  assign asmNext  = {outBit, asmReg[W-1:1]};
  assign crcNext  = {crc[CW-2:0], 1'b0} ^ ((crc[CW-1] ^ outBit) ? POLY : '0);

  assign flagNowReg    = (rawSh == FLAG);
  assign stat.flagHit  = bitEn && (rawNext == FLAG);
  assign stat.abortHit = bitEn && rxBit && (ones >= OCW'(ABORT - 1));
  assign stat.byteDone = useBit && (bitCnt == BCW'(W - 1));
  assign stat.lenOk    = (byteCnt != 2'd0);
  assign stat.crcOk    = (crcNext == GOOD);

  // raw stream: flag comparator input and run-of-ones counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawSh <= '0;
      ones  <= '0;
    end else if (bitEn) begin
      rawSh <= rawNext;
      if (!rxBit)
        ones <= '0;
      else if (ones != OCW'(ABORT))
        ones <= ones + 1'b1;
    end
  end

  // destuffed bits pass a W-deep delay so a flag is known before its bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dly <= '0;
    else if (keep) dly <= {rxBit, dly[W-1:1]};
  end

  // byte assembly and CRC on the delayed destuffed stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg  <= '0;
      bitCnt  <= '0;
      fill    <= '0;
      byteCnt <= '0;
      crc     <= INIT;
    end else if (cmd.frameRst) begin
      bitCnt  <= '0;
      fill    <= '0;
      byteCnt <= '0;
      crc     <= INIT;
    end else if (useBit) begin
      asmReg <= asmNext;
      crc    <= crcNext;
      bitCnt <= (bitCnt == BCW'(W - 1)) ? '0 : bitCnt + 1'b1;
      if (bitCnt == BCW'(W - 1) && byteCnt != 2'd2)
        byteCnt <= byteCnt + 1'b1;
    end else if (keep && !primed) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteData <= '0;
    else if (cmd.loadByte) byteData <= asmNext;
  end

endmodule

// File: rtl/sdlc_rx_ctl.sv
module sdlc_rx_ctl
  import sdlc_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    flagIdle,
  input  rxStat_t stat,
  input  logic    flagNowReg,
  output rxCmd_t  cmd,
  output logic    inSync,
  output logic    syncPulse,
  output logic    huntChange,
  output logic    byteValid,
  output logic    frameEnd,
  output logic    crcErr,
  output logic    abortSeen
);

  typedef enum logic {HUNT, SYNC} rxMode_e;
  rxMode_e mode;
  logic    emitEnd, emitMid;

  assign inSync = (mode == SYNC);

  always_comb begin
    emitEnd = inSync && stat.flagHit && stat.byteDone && stat.lenOk;
    emitMid = inSync && !stat.flagHit && !stat.abortHit && stat.byteDone;
    cmd.frameRst = bitEn && (!inSync || stat.flagHit || stat.abortHit);
    cmd.loadByte = emitEnd || emitMid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= HUNT;
      syncPulse  <= 1'b0;
      huntChange <= 1'b0;
      byteValid  <= 1'b0;
      frameEnd   <= 1'b0;
      crcErr     <= 1'b0;
      abortSeen  <= 1'b0;
    end else begin
      huntChange <= 1'b0;
      abortSeen  <= 1'b0;
      byteValid  <= cmd.loadByte;
      frameEnd   <= emitEnd;
      if (bitEn) syncPulse <= flagNowReg;
      if (emitEnd) crcErr <= !stat.crcOk;
      if (bitEn) begin
        case (mode)
          HUNT: if (stat.flagHit) begin
            mode       <= SYNC;
            huntChange <= 1'b1;
          end
          SYNC: if (stat.abortHit) begin
            mode       <= HUNT;
            abortSeen  <= 1'b1;
            huntChange <= !flagIdle;
          end
          default: mode <= HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdlc_rx_hunt.sv
module sdlc_rx_hunt
  import sdlc_rx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD = 16'h1D0F,
  parameter int unsigned STUFF_ONES = 5,
  parameter int unsigned ABORT_ONES = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              rxBit,
  input  logic              flagIdle,
  output logic              inSync,
  output logic              syncPulse,
  output logic              huntChange,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              frameEnd,
  output logic              crcErr,
  output logic              abortSeen
);

  rxCmd_t  cmd;
  rxStat_t stat;
  logic    flagNowReg;

  sdlc_rx_dp #(
    .W(BYTE_W), .CW(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT),
    .GOOD(CRC_GOOD), .STUFF(STUFF_ONES), .ABORT(ABORT_ONES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .cmd(cmd),
    .stat(stat), .flagNowReg(flagNowReg), .byteData(byteData)
  );

  sdlc_rx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .flagIdle(flagIdle),
    .stat(stat), .flagNowReg(flagNowReg), .cmd(cmd), .inSync(inSync),
    .syncPulse(syncPulse), .huntChange(huntChange), .byteValid(byteValid),
    .frameEnd(frameEnd), .crcErr(crcErr), .abortSeen(abortSeen)
  );

endmodule

// File: rtl/sdlc_rx_chk.sv
module sdlc_rx_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic flagIdle,
  input logic inSync,
  input logic syncPulse,
  input logic huntChange,
  input logic byteValid,
  input logic frameEnd,
  input logic abortSeen
);

  // R2
  rose_sync_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> huntChange);

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(syncPulse));

  // R3
  sync_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncPulse && bitEn) |=> !syncPulse);

  // R4
  byte_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(bitEn));

  // R5
  end_with_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> byteValid);

  // R8
  abort_hunt_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortSeen |-> !inSync);

  // R8
  fell_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSync) |-> abortSeen);

  // R8
  abort_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortSeen && !$past(flagIdle)) |-> huntChange);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortSeen && $past(flagIdle)) |-> !huntChange);

  // R10
  hunt_no_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(inSync));

endmodule

bind sdlc_rx_hunt sdlc_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .flagIdle(flagIdle),
  .inSync(inSync), .syncPulse(syncPulse), .huntChange(huntChange),
  .byteValid(byteValid), .frameEnd(frameEnd), .abortSeen(abortSeen)
);

// File: tb/sim_sdlc_rx_hunt.sv
module sim_sdlc_rx_hunt;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b1;
  logic       flagIdle = 1'b0;
  logic       inSync, syncPulse, huntChange, byteValid, frameEnd, crcErr, abortSeen;
  logic [7:0] byteData;

  int checks = 0;
  int errors = 0;
  int nByte = 0, nEnd = 0, nAbort = 0, nHunt = 0;
  bit done = 1'b0;

  logic [9:0] expQ [$];       // {eof, err, data}
  logic [7:0] fbuf [0:15];
  int         flen;

  always #10 clk = ~clk;      // 50 MHz

  sdlc_rx_hunt u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .flagIdle(flagIdle),
    .inSync(inSync), .syncPulse(syncPulse), .huntChange(huntChange),
    .byteValid(byteValid), .byteData(byteData), .frameEnd(frameEnd),
    .crcErr(crcErr), .abortSeen(abortSeen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and event counting
  always @(negedge clk) begin
    if (rstN) begin
      if (huntChange) nHunt++;
      if (abortSeen) nAbort++;
      if (frameEnd) nEnd++;
      if (byteValid) begin
        nByte++;
        if (expQ.size() == 0) begin
          check(1'b0, "R7/R10 unexpected byte", int'(byteData), 0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          check(byteData == e[7:0], "R4 byte value", int'(byteData), int'(e[7:0]));
          check(frameEnd == e[9], "R5 frame end position", int'(frameEnd), int'(e[9]));
          if (e[9]) check(crcErr == e[8], "R6 crc verdict", int'(crcErr), int'(e[8]));
        end
      end
    end
  end

  task automatic sendBit(input logic b);
    @(negedge clk);
    rxBit = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendFlag();
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
  endtask

  task automatic sendRawByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  // sends fbuf[0..n-1] LSB first with zero insertion after five ones
  task automatic sendStuffed(input int n);
    int ones = 0;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        sendBit(fbuf[k][i]);
        if (fbuf[k][i]) ones++; else ones = 0;
        if (ones == 5) begin
          sendBit(1'b0);
          ones = 0;
        end
      end
    end
  endtask

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  // frame body from fbuf[0..flen-1], optional CRC, closing flag
  task automatic sendFrame(input bit withCrc, input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] t;
    int nb = flen;
    if (withCrc) begin
      for (int k = 0; k < flen; k++)
        for (int i = 0; i < 8; i++) c = crcStep(c, fbuf[k][i]);
      t = ~c;
      for (int i = 0; i < 8; i++) begin
        fbuf[flen][i]   = t[15 - i];
        fbuf[flen+1][i] = t[7 - i];
      end
      if (corrupt) fbuf[flen+1][0] = ~fbuf[flen+1][0];
      nb = flen + 2;
    end
    if (nb >= 2)
      for (int k = 0; k < nb; k++)
        expQ.push_back({(k == nb - 1), (k == nb - 1) && corrupt, fbuf[k]});
    sendStuffed(nb);
    sendFlag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hb, bb, eb, ab;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(!inSync && !syncPulse && !byteValid && !frameEnd && !crcErr && !abortSeen && !huntChange,
          "R1 reset outputs", int'({inSync, syncPulse, byteValid, frameEnd, crcErr, abortSeen}), 0);

    // R10 hunt ignores data
    sendRawByte(8'h3C);
    sendRawByte(8'hA5);
    sendRawByte(8'h00);
    check(nByte == 0 && nEnd == 0, "R10 hunt produces no bytes", nByte + nEnd, 0);
    check(!inSync, "R10 still hunting", int'(inSync), 0);

    // R2 opening flag
    sendFlag();
    check(inSync, "R2 sync after flag", int'(inSync), 1);
    check(nHunt == 1, "R2 one status event", nHunt, 1);

    // R3 sync pulse timing, then an idle flag
    check(!syncPulse, "R3 pulse not yet", int'(syncPulse), 0);
    sendBit(1'b0);
    check(syncPulse, "R3 pulse one bit later", int'(syncPulse), 1);
    sendBit(1'b1);
    check(!syncPulse, "R3 pulse one bit long", int'(syncPulse), 0);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sendBit(1'b0);
    check(nHunt == 1 && inSync, "R3 idle flag keeps sync", nHunt, 1);

    // R4 R5 R6 good frame with stuffing inside 0xFF
    fbuf[0] = 8'h81; fbuf[1] = 8'h42; fbuf[2] = 8'hFF; fbuf[3] = 8'h42; flen = 4;
    sendFrame(1'b1, 1'b0);
    check(nEnd == 1, "R5 one frame end", nEnd, 1);
    check(nByte == 6, "R5 crc bytes delivered", nByte, 6);
    check(!crcErr, "R6 good crc", int'(crcErr), 0);

    // R6 corrupted crc, flag-like payload
    fbuf[0] = 8'h7E; fbuf[1] = 8'h3F; fbuf[2] = 8'hF8; flen = 3;
    sendFrame(1'b1, 1'b1);
    check(crcErr, "R6 bad crc flagged", int'(crcErr), 1);

    // R6 clean frame clears verdict
    fbuf[0] = 8'h00; flen = 1;
    sendFrame(1'b1, 1'b0);
    check(!crcErr && nEnd == 3, "R6 verdict cleared", int'(crcErr), 0);

    // R7 one-byte frame discarded
    bb = nByte; eb = nEnd;
    fbuf[0] = 8'h5A; flen = 1;
    sendFrame(1'b0, 1'b0);
    check(nByte == bb, "R7 short frame no byte", nByte, bb);
    check(nEnd == eb, "R7 short frame no end", nEnd, eb);

    // R8 abort mid-frame, flagIdle = 0
    hb = nHunt; ab = nAbort; eb = nEnd;
    fbuf[0] = 8'h11; fbuf[1] = 8'h22;
    expQ.push_back({1'b0, 1'b0, 8'h11});
    sendStuffed(2);
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    check(!inSync, "R8 abort to hunt", int'(inSync), 0);
    check(nAbort == ab + 1, "R8 abort event", nAbort, ab + 1);
    check(nHunt == hb + 1, "R8 status event", nHunt, hb + 1);
    check(nEnd == eb, "R8 no frame end", nEnd, eb);

    // resync, then R9 abort with flagIdle = 1
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    sendFlag();
    check(inSync && nHunt == hb + 2, "R2 resync event", nHunt, hb + 2);
    flagIdle = 1'b1;
    hb = nHunt; ab = nAbort;
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    check(!inSync, "R9 abort to hunt", int'(inSync), 0);
    check(nAbort == ab + 1, "R9 abort event", nAbort, ab + 1);
    check(nHunt == hb, "R9 status event suppressed", nHunt, hb);

    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R5 all expected bytes seen", expQ.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule